// File: doc/BRIEF.md
# Serial Scaled Min-Sum Layer Processor

This block performs the check-node work for one layer of a block-structured parity check matrix inside a layered LDPC decoder. It handles a fixed number of parallel check rows (lanes) and takes one block column per accepted beat. Each beat carries one 8-bit posterior value and one 8-bit previous check message per lane. Message memories, circulant rotation and iteration control sit outside the block.

The work is split into two passes. In the collect pass, every incoming column has its old check message removed from the posterior. The resulting variable-to-check value is stored locally. It also feeds a statistics core that tracks, per lane, the smallest and second smallest magnitude, the column where the smallest one appeared, and the parity of all signs. When the layer ends, the block enters the emit pass. There it replays the stored columns in arrival order. For each column it outputs the new scaled min-sum check message and the refreshed posterior, so the next layer can use the updated values immediately.

Both sides use valid/ready handshakes. A start marker and an end marker frame each layer. The layer also closes by itself when its column count reaches the local storage depth.

Top module: `minsum_layer_proc`

## Requirements
- R1: Per lane, the variable-to-check value is the posterior minus the previous check message. Both are 8-bit two's complement, and lane l occupies bits [8l+7:8l]. The result is saturated to the symmetric range -127..127.
- R2: Over the columns of a layer, each lane tracks three statistics. The first is the smallest variable-to-check magnitude, and its column index is the first column that reaches that value. The second is the smallest magnitude among all other columns. The third is the XOR of all sign bits, where bit 7 set means negative and zero counts as positive.
- R3: The outgoing magnitude for a column is the second minimum at the first minimum's own column and the first minimum at every other column. It is then scaled to x - floor(x/4).
- R4: The outgoing sign is the total sign parity XOR that column's own variable-to-check sign. The message is the negated magnitude when the sign is 1 and the magnitude when it is 0.
- R5: The new posterior is the variable-to-check value plus the new check message, saturated to -127..127.
- R6: In the collect pass in_ready is high, and each handshake takes one column. A column with in_first set restarts the layer at column 0 and discards any earlier columns of an unfinished layer. A column with in_last set ends the layer.
- R7: The emit pass has four properties. out_valid rises in the cycle after the final column is accepted. Columns come out in arrival order, and out_last marks the final one. in_ready stays low throughout, and input beats offered then are ignored. After the final output handshake, in_ready returns high and out_valid falls.
- R8: While out_valid is high and out_ready is low, out_msg, out_post and out_last hold their values.
- R9: A column accepted at index MAX_COLS-1 ends the layer even when in_last is low.
- R10: In a single-column layer the second minimum is 127, so that column's message magnitude is 96.
- R11: After reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input column offered |
| in_ready | output | 1 | Block can take a column (collect pass) |
| in_first | input | 1 | Column is the first of a layer |
| in_last | input | 1 | Column is the last of a layer |
| in_post | input | LANES*8 | Posterior values, one per lane |
| in_cmsg | input | LANES*8 | Previous check messages, one per lane |
| out_valid | output | 1 | Output column valid |
| out_ready | input | 1 | Consumer accepts output column |
| out_msg | output | LANES*8 | New check messages |
| out_post | output | LANES*8 | Updated posteriors |
| out_last | output | 1 | Output column is the last of the layer |

## Verification
The bench attacks five corner cases.

- Equal magnitudes across columns: a design that moved the minimum index on a tie, or left the second minimum unset, would give the wrong column the larger message.
- Extreme inputs that overflow subtraction and addition: missing or asymmetric saturation shows up as wrapped values or -128.
- Single-column layers and layers that close by reaching the storage depth: these expose wrong initial statistics and a column counter that fails to end the layer.
- A mid-layer restart: this catches leftover statistics.
- Output stalls, with junk beats offered during the emit pass: these catch a design that advances or corrupts its replay under backpressure.

// File: rtl/minsum_pkg.sv
package minsum_pkg;
  localparam int MSG_W   = 8;
  localparam int MAG_W   = MSG_W - 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  typedef logic signed [MSG_W-1:0] msg_t;
  typedef logic [MAG_W-1:0]        mag_t;

  // symmetric clip of a one-bit-wider sum to +/-MAG_MAX
  function automatic msg_t clip_sym(input logic signed [MSG_W:0] x);
    if (x > MAG_MAX)  return msg_t'(MAG_MAX);
    if (x < -MAG_MAX) return msg_t'(-MAG_MAX);
    return x[MSG_W-1:0];
  endfunction

  function automatic msg_t sub_sat(input msg_t a, input msg_t b);
    logic signed [MSG_W:0] d;
    d = {a[MSG_W-1], a} - {b[MSG_W-1], b};
    return clip_sym(d);
  endfunction

  function automatic msg_t add_sat(input msg_t a, input msg_t b);
    logic signed [MSG_W:0] s;
    s = {a[MSG_W-1], a} + {b[MSG_W-1], b};
    return clip_sym(s);
  endfunction

  function automatic logic is_neg(input msg_t v);
    return v[MSG_W-1];
  endfunction

  // valid for clipped values only (never -2^(MSG_W-1))
  function automatic mag_t mag_of(input msg_t v);
    msg_t n;
    n = -v;
    return v[MSG_W-1] ? n[MAG_W-1:0] : v[MAG_W-1:0];
  endfunction

  // 0.75 scaling without a multiplier
  function automatic mag_t scale_34(input mag_t m);
    return m - (m >> 2);
  endfunction

  function automatic msg_t apply_sign(input logic s, input mag_t m);
    msg_t p;
    p = msg_t'({1'b0, m});
    return s ? -p : p;
  endfunction
endpackage

// File: rtl/minsum_col_buf.sv
module minsum_col_buf #(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = LANES * minsum_pkg::MSG_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/minsum_find_core.sv
module minsum_find_core
  import minsum_pkg::*;
#(
  parameter int LANES = 4,
  parameter int COL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic                   start,
  input  logic [COL_W-1:0]       col,
  input  logic [LANES*MSG_W-1:0] v2c,
  output logic [LANES*MAG_W-1:0] min1,
  output logic [LANES*MAG_W-1:0] min2,
  output logic [LANES*COL_W-1:0] idx,
  output logic [LANES-1:0]       sgn
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    msg_t             v;
    mag_t             m;
    mag_t             r_min1, r_min2;
    logic [COL_W-1:0] r_idx;
    logic             r_sgn;
    logic             new_low, new_second;

    assign v          = v2c[l*MSG_W +: MSG_W];
    assign m          = mag_of(v);
    assign new_low    = m < r_min1;
    assign new_second = !new_low && (m < r_min2);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_min1 <= mag_t'(MAG_MAX);
        r_min2 <= mag_t'(MAG_MAX);
        r_idx  <= '0;
        r_sgn  <= 1'b0;
      end else if (upd) begin
        if (start) begin
          r_min1 <= m;
          r_min2 <= mag_t'(MAG_MAX);
          r_idx  <= col;
          r_sgn  <= is_neg(v);
        end else begin
          r_sgn <= r_sgn ^ is_neg(v);
          if (new_low) begin
            r_min2 <= r_min1;
            r_min1 <= m;
            r_idx  <= col;
          end else if (new_second) begin
            r_min2 <= m;
          end
        end
      end
    end

    assign min1[l*MAG_W +: MAG_W] = r_min1;
    assign min2[l*MAG_W +: MAG_W] = r_min2;
    assign idx[l*COL_W +: COL_W]  = r_idx;
    assign sgn[l]                 = r_sgn;

    // R2: ordering of the two tracked minima
    p_min_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      r_min1 <= r_min2);
  end
endmodule

// File: rtl/minsum_update_core.sv
module minsum_update_core
  import minsum_pkg::*;
#(
  parameter int LANES = 4,
  parameter int COL_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic [COL_W-1:0]       col,
  input  logic [LANES*MSG_W-1:0] v2c,
  input  logic [LANES*MAG_W-1:0] min1,
  input  logic [LANES*MAG_W-1:0] min2,
  input  logic [LANES*COL_W-1:0] idx,
  input  logic [LANES-1:0]       sgn,
  output logic [LANES*MSG_W-1:0] new_msg,
  output logic [LANES*MSG_W-1:0] new_post
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    msg_t v, c, p;
    mag_t sel, sc;
    logic at_min, s;

    assign v      = v2c[l*MSG_W +: MSG_W];
    assign at_min = (col == idx[l*COL_W +: COL_W]);
    assign sel    = at_min ? min2[l*MAG_W +: MAG_W] : min1[l*MAG_W +: MAG_W];
    assign sc     = scale_34(sel);
    assign s      = sgn[l] ^ is_neg(v);
    assign c      = apply_sign(s, sc);
    assign p      = add_sat(v, c);

    assign new_msg[l*MSG_W +: MSG_W]  = c;
    assign new_post[l*MSG_W +: MSG_W] = p;

    // R3: scaled message magnitude never exceeds 0.75 of full scale
    p_msg_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (mag_of(c) <= scale_34(mag_t'(MAG_MAX))));
    // R5: posterior stays inside the symmetric range
    p_post_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (p != msg_t'(-(MAG_MAX + 1))));
  end
endmodule

// File: rtl/minsum_layer_proc.sv
module minsum_layer_proc
  import minsum_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int MAX_COLS = 8,
  localparam int COL_W   = $clog2(MAX_COLS),
  localparam int BUS_W   = LANES * MSG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [BUS_W-1:0] in_post,
  input  logic [BUS_W-1:0] in_cmsg,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_msg,
  output logic [BUS_W-1:0] out_post,
  output logic             out_last
);
  typedef enum logic {ST_COLLECT, ST_EMIT} state_t;

  state_t           state;
  logic [COL_W-1:0] cnt, last_idx, rd_idx;
  logic [COL_W-1:0] cidx;
  logic [BUS_W-1:0] v2c_in, v2c_rd;
  logic [LANES*MAG_W-1:0] st_min1, st_min2;
  logic [LANES*COL_W-1:0] st_idx;
  logic [LANES-1:0]       st_sgn;

  // named events
  logic accept, col_start, hit_depth, layer_done, emit_fire, emit_end;

  assign in_ready   = (state == ST_COLLECT);
  assign out_valid  = (state == ST_EMIT);
  assign accept     = in_valid && in_ready;
  assign cidx       = in_first ? '0 : cnt;
  assign col_start  = (cidx == '0);
  assign hit_depth  = (cidx == COL_W'(MAX_COLS - 1));
  assign layer_done = accept && (in_last || hit_depth);
  assign emit_fire  = out_valid && out_ready;
  assign out_last   = out_valid && (rd_idx == last_idx);
  assign emit_end   = emit_fire && (rd_idx == last_idx);

  for (genvar l = 0; l < LANES; l++) begin : g_v2c
    assign v2c_in[l*MSG_W +: MSG_W] =
      sub_sat(in_post[l*MSG_W +: MSG_W], in_cmsg[l*MSG_W +: MSG_W]);

    // R1: no value at the asymmetric extreme enters the layer
    p_v2c_sym_r1: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (v2c_in[l*MSG_W +: MSG_W] != msg_t'(-(MAG_MAX + 1))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_COLLECT;
      cnt      <= '0;
      last_idx <= '0;
      rd_idx   <= '0;
    end else begin
      case (state)
        ST_COLLECT: begin
          if (layer_done) begin
            state    <= ST_EMIT;
            last_idx <= cidx;
            cnt      <= '0;
            rd_idx   <= '0;
          end else if (accept) begin
            cnt <= cidx + COL_W'(1);
          end
        end
        ST_EMIT: begin
          if (emit_end) state <= ST_COLLECT;
          else if (emit_fire) rd_idx <= rd_idx + COL_W'(1);
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  minsum_col_buf #(.LANES(LANES), .DEPTH(MAX_COLS)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (cidx),
    .wdata (v2c_in),
    .raddr (rd_idx),
    .rdata (v2c_rd)
  );

  minsum_find_core #(.LANES(LANES), .COL_W(COL_W)) u_find (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (accept),
    .start (col_start),
    .col   (cidx),
    .v2c   (v2c_in),
    .min1  (st_min1),
    .min2  (st_min2),
    .idx   (st_idx),
    .sgn   (st_sgn)
  );

  minsum_update_core #(.LANES(LANES), .COL_W(COL_W)) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (out_valid),
    .col      (rd_idx),
    .v2c      (v2c_rd),
    .min1     (st_min1),
    .min2     (st_min2),
    .idx      (st_idx),
    .sgn      (st_sgn),
    .new_msg  (out_msg),
    .new_post (out_post)
  );

  // R7: emit pass starts right after the closing column
  p_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |=> (out_valid && !in_ready));
  // R7: collect pass resumes after the final output handshake
  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_fire && out_last) |=> (in_ready && !out_valid));
  // R8: stalled outputs stay put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_msg) && $stable(out_post) && $stable(out_last)));
  // R9: reaching the storage depth closes the layer
  p_autoend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_last && hit_depth) |=> out_valid);
endmodule

// File: tb/minsum_layer_proc_tb.sv
`timescale 1ns/1ps
module minsum_layer_proc_tb;
  localparam int L    = 4;
  localparam int MAXC = 8;
  localparam int BW   = L * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [BW-1:0] in_post = '0, in_cmsg = '0;
  logic in_ready, out_valid, out_last;
  logic [BW-1:0] out_msg, out_post;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int pq [MAXC][L];
  int oq [MAXC][L];
  logic [BW-1:0] exp_msg [MAXC];
  logic [BW-1:0] exp_post[MAXC];

  always #2 clk = ~clk;

  minsum_layer_proc #(.LANES(L), .MAX_COLS(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_last(in_last),
    .in_post(in_post), .in_cmsg(in_cmsg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_msg(out_msg), .out_post(out_post), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int clip(input int x);
    if (x > 127) return 127;
    if (x < -127) return -127;
    return x;
  endfunction

  function automatic int s8(input int x);
    int y;
    y = x & 255;
    return (y > 127) ? y - 256 : y;
  endfunction

  // reference: restate the min-sum rule over whole columns
  task automatic model(input int n);
    for (int l = 0; l < L; l++) begin
      int v[MAXC];
      int a[MAXC];
      int m1, ix, m2, par;
      m1 = 1000; ix = 0; par = 0;
      for (int c = 0; c < n; c++) begin
        v[c] = clip(s8(pq[c][l]) - s8(oq[c][l]));
        a[c] = (v[c] < 0) ? -v[c] : v[c];
        if (v[c] < 0) par ^= 1;
      end
      for (int c = n - 1; c >= 0; c--) if (a[c] <= m1) begin m1 = a[c]; ix = c; end
      m2 = 127;
      for (int c = 0; c < n; c++) if (c != ix && a[c] < m2) m2 = a[c];
      for (int c = 0; c < n; c++) begin
        int sel, mg, sg, msg;
        sel = (c == ix) ? m2 : m1;
        mg  = (3 * sel + 3) / 4;
        sg  = par ^ ((v[c] < 0) ? 1 : 0);
        msg = sg ? -mg : mg;
        exp_msg[c][l*8 +: 8]  = 8'(msg);
        exp_post[c][l*8 +: 8] = 8'(clip(v[c] + msg));
      end
    end
  endtask

  task automatic drive_col(input int c, input bit first, input bit last);
    in_valid = 1'b1; in_first = first; in_last = last;
    for (int l = 0; l < L; l++) begin
      in_post[l*8 +: 8] = 8'(pq[c][l]);
      in_cmsg[l*8 +: 8] = 8'(oq[c][l]);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic run_layer(input int n, input bit use_last, input bit bp,
                           input bit junk, input string tag);
    model(n);
    for (int c = 0; c < n; c++) begin
      drive_col(c, c == 0, use_last && (c == n - 1));
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    for (int e = 0; e < n; e++) begin
      if (junk) begin
        in_valid = 1'b1; in_first = 1'b1; in_last = 1'b1;
        in_post = BW'($urandom); in_cmsg = BW'($urandom);
        chk(in_ready == 1'b0, "R7", "in_ready low in emit", BW'(in_ready), '0);
      end
      chk(out_valid == 1'b1, "R7", "out_valid", BW'(out_valid), BW'(1));
      chk(out_msg == exp_msg[e], tag, $sformatf("msg col %0d", e), out_msg, exp_msg[e]);
      chk(out_post == exp_post[e], tag, $sformatf("post col %0d", e), out_post, exp_post[e]);
      chk(out_last == (e == n - 1), "R7", "out_last", BW'(out_last), BW'(e == n - 1));
      if (bp) begin
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid && out_msg == exp_msg[e] && out_post == exp_post[e] &&
            out_last == (e == n - 1), "R8", $sformatf("hold col %0d", e),
            out_msg, exp_msg[e]);
        out_ready = 1'b1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R7", "back to collect",
        BW'({out_valid, in_ready}), BW'(2'b01));
  endtask

  task automatic fill_random(input int n);
    for (int c = 0; c < n; c++)
      for (int l = 0; l < L; l++) begin
        pq[c][l] = s8($urandom);
        oq[c][l] = s8($urandom % 64) - 32;
      end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R11", "reset state",
        BW'({in_ready, out_valid}), BW'(2'b10));
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      int n;
      n = 3 + (k % 6);
      fill_random(n);
      run_layer(n, 1'b1, 1'b0, 1'b0, "R2 R3 R4 R5");
    end
  endtask

  task automatic t_ties();
    for (int c = 0; c < 5; c++)
      for (int l = 0; l < L; l++) begin
        pq[c][l] = ((c + l) % 2) ? -20 : 20;
        oq[c][l] = 0;
      end
    pq[3][2] = 5;  pq[1][2] = 5;
    run_layer(5, 1'b1, 1'b0, 1'b0, "R2 R3");
  endtask

  task automatic t_saturate();
    for (int c = 0; c < 4; c++)
      for (int l = 0; l < L; l++) begin
        pq[c][l] = (c % 2) ? -128 : 127;
        oq[c][l] = (c % 2) ? 127 : -128;
      end
    pq[2][1] = 120; oq[2][1] = 0;
    pq[3][3] = -126; oq[3][3] = 0;
    run_layer(4, 1'b1, 1'b0, 1'b0, "R1 R5");
  endtask

  task automatic t_single();
    for (int l = 0; l < L; l++) begin pq[0][l] = 10 * l - 15; oq[0][l] = 0; end
    run_layer(1, 1'b1, 1'b0, 1'b0, "R10");
  endtask

  task automatic t_restart();
    fill_random(2);
    drive_col(0, 1'b1, 1'b0); @(negedge clk);
    drive_col(1, 1'b0, 1'b0); @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R6", "still collecting",
        BW'({in_ready, out_valid}), BW'(2'b10));
    fill_random(4);
    run_layer(4, 1'b1, 1'b0, 1'b0, "R6");
  endtask

  task automatic t_maxcols();
    fill_random(MAXC);
    run_layer(MAXC, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_backpressure();
    fill_random(5);
    run_layer(5, 1'b1, 1'b1, 1'b0, "R8");
  endtask

  task automatic t_ignore();
    fill_random(4);
    run_layer(4, 1'b1, 1'b0, 1'b1, "R7");
    fill_random(3);
    run_layer(3, 1'b1, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_random();
    t_ties();
    t_saturate();
    t_single();
    t_restart();
    t_maxcols();
    t_backpressure();
    t_ignore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule